// File: doc/BRIEF.md
# Multilevel Phase-Change Weight Programmer

This block stores one 4-bit weight in a cell built from fifteen phase-change segments, and it drives each segment's heater on its own enable line. The weight is not kept as binary bits. It is kept as a count of crystalline segments, so level L means segments 0 to L−1 are crystalline and all others are amorphous. When a new weight is requested, the block works out which segments lie between the old and the new level. Only those segments are pulsed. Raising the level anneals segments into the crystalline state with a long, moderate pulse train. Lowering the level melts segments back to amorphous with a short, intense pulse train.

The anneal and melt trains each have their own programmable pulse count, on-time and period. A settle gap, used only in serial mode, separates consecutive segment trains. In parallel mode every changing segment is heated at once, so an update costs a single train. In serial mode one segment is heated at a time: the lowest index goes first when raising and the highest goes first when lowering. Reading the stored weight never causes a write.

After reset the block does not know the state of the cell. The first command therefore melts all fifteen segments and then anneals up to the requested level.

Top module: `pcm_weight_prog`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. A command is taken on a clock edge where `req_valid` and `req_ready` are both high. A request made while busy has no effect on the update in progress and is taken only once the block is idle again.
- R2: The block raises `done` for one cycle when an update finishes. In that same cycle `stored_code` shows the requested code and `stored_valid` is 1.
- R3: When raising from level A to level B (with B > A), only segments A..B−1 are heated, and `pulse_melt` is 0 while they are being pulsed.
- R4: When lowering from level A to level B (with B < A), only segments B..A−1 are heated, and `pulse_melt` is 1 while they are being pulsed.
- R5: A command equal to the stored code heats no segment. It raises `done` in the cycle right after it is taken.
- R6: Each train has count × period cycles. The heater is on during the first on-time cycles of each period, or for the whole period if on-time is at least the period. A count, on-time or period of 0 is treated as 1. The anneal fields apply to raising and the melt fields apply to lowering.
- R7: With `cfg_serial` = 0, every segment in the change window is heated during the same cycles, using one train per phase.
- R8: With `cfg_serial` = 1, at most one heater is on at a time. The order is ascending when raising and descending when lowering. Between consecutive segment trains there are `cfg_settle` cycles with all heaters off.
- R9: After reset, `stored_valid` is 0. The first command melts all fifteen segments and then anneals segments 0..code−1; the anneal phase is skipped for code 0.
- R10: `stored_code` changes only in a cycle where `done` is high. While the block is idle, no heater is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | High while idle; command accepted when both high |
| req_code | input | 4 | Requested weight level, 0 to 15 |
| cfg_serial | input | 1 | 1 = one segment at a time, 0 = all changing segments together |
| cfg_anneal_cnt | input | 8 | Anneal pulses per train |
| cfg_anneal_on | input | 16 | Anneal heater-on cycles per pulse |
| cfg_anneal_per | input | 16 | Anneal pulse period in cycles |
| cfg_melt_cnt | input | 8 | Melt pulses per train |
| cfg_melt_on | input | 16 | Melt heater-on cycles per pulse |
| cfg_melt_per | input | 16 | Melt pulse period in cycles |
| cfg_settle | input | 16 | Heater-off gap between serial segment trains |
| heat_en | output | 15 | Per-segment heater enable; bit k drives segment k |
| pulse_melt | output | 1 | 1 while a melt train runs, 0 otherwise |
| done | output | 1 | One-cycle update-finished pulse |
| stored_code | output | 4 | Current stored level |
| stored_valid | output | 1 | Level known, i.e. at least one update has finished since reset |

## Verification
Two events can land in the same cycle: the completion of an update and a new request that has been waiting since the update was in progress. The bench raises a request with a different code in the middle of an update and keeps it asserted through the `done` cycle. It then checks three things. First, the heater pattern of the running update is unchanged. Second, `req_ready` stays low in the `done` cycle. Third, the held command starts only after one idle cycle, and it starts from the level just stored. Every cycle is compared against a model that expands each command into its expected stream of heater masks, pulse types and done flags.

// File: rtl/pcm_prog_pkg.sv
package pcm_prog_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PULSE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_DONE   = 2'd3
  } prog_state_t;

  // zero in a timing field is taken as one
  function automatic logic [15:0] floor_one16(input logic [15:0] v);
    return (v == 16'd0) ? 16'd1 : v;
  endfunction

  function automatic logic [7:0] floor_one8(input logic [7:0] v);
    return (v == 8'd0) ? 8'd1 : v;
  endfunction

endpackage

// File: rtl/pcm_pulse_timer.sv
module pcm_pulse_timer #(
  parameter int TW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [TW-1:0] on_time,
  input  logic [TW-1:0] period,
  input  logic [CW-1:0] count,
  output logic          active,
  output logic          train_end
);
  import pcm_prog_pkg::*;

  logic [TW-1:0] slot;
  logic [CW-1:0] idx;
  logic [TW-1:0] on_e, per_e;
  logic [CW-1:0] cnt_e;
  logic          slot_last, idx_last;

  assign on_e      = floor_one16(on_time);
  assign per_e     = floor_one16(period);
  assign cnt_e     = floor_one8(count);
  assign slot_last = (slot == per_e - 1'b1);
  assign idx_last  = (idx == cnt_e - 1'b1);
  assign active    = run && (slot < on_e);
  assign train_end = run && slot_last && idx_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
      idx  <= '0;
    end else if (!run) begin
      slot <= '0;
      idx  <= '0;
    end else if (slot_last) begin
      slot <= '0;
      idx  <= idx_last ? '0 : idx + 1'b1;
    end else begin
      slot <= slot + 1'b1;
    end
  end
endmodule

// File: rtl/pcm_seg_select.sv
module pcm_seg_select #(
  parameter int NSEG = 15,
  parameter int IW   = 5
) (
  input  logic            en,
  input  logic            serial,
  input  logic [IW-1:0]   lo,
  input  logic [IW-1:0]   hi,
  input  logic [IW-1:0]   cur,
  output logic [NSEG-1:0] heat
);
  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    localparam logic [IW-1:0] KIDX = IW'(k);
    logic in_win, hit;
    assign in_win  = (KIDX >= lo) && (KIDX < hi);
    assign hit     = serial ? (KIDX == cur) : in_win;
    assign heat[k] = en && hit;
  end
endmodule

// File: rtl/pcm_weight_prog.sv
module pcm_weight_prog #(
  parameter int WBITS = 4,
  parameter int TW    = 16,
  parameter int CW    = 8,
  localparam int NSEG = (1 << WBITS) - 1,
  localparam int IW   = WBITS + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [WBITS-1:0] req_code,
  input  logic             cfg_serial,
  input  logic [CW-1:0]    cfg_anneal_cnt,
  input  logic [TW-1:0]    cfg_anneal_on,
  input  logic [TW-1:0]    cfg_anneal_per,
  input  logic [CW-1:0]    cfg_melt_cnt,
  input  logic [TW-1:0]    cfg_melt_on,
  input  logic [TW-1:0]    cfg_melt_per,
  input  logic [TW-1:0]    cfg_settle,
  output logic [NSEG-1:0]  heat_en,
  output logic             pulse_melt,
  output logic             done,
  output logic [WBITS-1:0] stored_code,
  output logic             stored_valid
);
  import pcm_prog_pkg::*;

  prog_state_t      state;
  logic             kind_melt, pend_anneal, known;
  logic [IW-1:0]    lo, hi, cur;
  logic [WBITS-1:0] target, value;
  logic [TW-1:0]    settle_tmr;

  // named events for the checker
  logic accept, busy, pulsing, train_end, pulse_active, seg_more, gap_on;

  assign req_ready = (state == ST_IDLE);
  assign busy      = !req_ready;
  assign accept    = req_valid && req_ready;
  assign pulsing   = (state == ST_PULSE);
  assign seg_more  = cfg_serial && (kind_melt ? (cur > lo) : (cur + 1'b1 < hi));
  assign gap_on    = cfg_serial && (cfg_settle != '0);

  pcm_pulse_timer #(.TW(TW), .CW(CW)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (pulsing),
    .on_time   (kind_melt ? cfg_melt_on  : cfg_anneal_on),
    .period    (kind_melt ? cfg_melt_per : cfg_anneal_per),
    .count     (kind_melt ? cfg_melt_cnt : cfg_anneal_cnt),
    .active    (pulse_active),
    .train_end (train_end)
  );

  pcm_seg_select #(.NSEG(NSEG), .IW(IW)) u_select (
    .en     (pulse_active),
    .serial (cfg_serial),
    .lo     (lo),
    .hi     (hi),
    .cur    (cur),
    .heat   (heat_en)
  );

  assign pulse_melt   = pulsing && kind_melt;
  assign done         = (state == ST_DONE);
  assign stored_code  = value;
  assign stored_valid = known;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      kind_melt   <= 1'b0;
      pend_anneal <= 1'b0;
      known       <= 1'b0;
      lo          <= '0;
      hi          <= '0;
      cur         <= '0;
      target      <= '0;
      value       <= '0;
      settle_tmr  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          target <= req_code;
          if (!known) begin
            kind_melt   <= 1'b1;
            lo          <= '0;
            hi          <= IW'(NSEG);
            cur         <= IW'(NSEG - 1);
            pend_anneal <= (req_code != '0);
            state       <= ST_PULSE;
          end else if (req_code == value) begin
            state <= ST_DONE;
          end else if (req_code > value) begin
            kind_melt   <= 1'b0;
            lo          <= {1'b0, value};
            hi          <= {1'b0, req_code};
            cur         <= {1'b0, value};
            pend_anneal <= 1'b0;
            state       <= ST_PULSE;
          end else begin
            kind_melt   <= 1'b1;
            lo          <= {1'b0, req_code};
            hi          <= {1'b0, value};
            cur         <= {1'b0, value} - 1'b1;
            pend_anneal <= 1'b0;
            state       <= ST_PULSE;
          end
        end
        ST_PULSE: if (train_end) begin
          settle_tmr <= '0;
          if (seg_more) begin
            cur   <= kind_melt ? cur - 1'b1 : cur + 1'b1;
            state <= gap_on ? ST_SETTLE : ST_PULSE;
          end else if (pend_anneal) begin
            pend_anneal <= 1'b0;
            kind_melt   <= 1'b0;
            lo          <= '0;
            hi          <= {1'b0, target};
            cur         <= '0;
            state       <= gap_on ? ST_SETTLE : ST_PULSE;
          end else begin
            value <= target;
            known <= 1'b1;
            state <= ST_DONE;
          end
        end
        ST_SETTLE: begin
          if (settle_tmr == cfg_settle - 1'b1) state <= ST_PULSE;
          else settle_tmr <= settle_tmr + 1'b1;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcm_weight_prog_chk.sv
module pcm_weight_prog_chk #(
  parameter int WBITS = 4,
  parameter int NSEG  = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [WBITS-1:0] req_code,
  input logic [NSEG-1:0]  heat_en,
  input logic             done,
  input logic [WBITS-1:0] stored_code,
  input logic             stored_valid,
  input logic             cfg_serial,
  input logic             accept
);
  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_equal_quick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && stored_valid && (req_code == stored_code) |=> done && (heat_en == '0));

  assert_serial_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_serial |-> $onehot0(heat_en));

  assert_code_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(stored_code));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (heat_en == '0));
endmodule

bind pcm_weight_prog pcm_weight_prog_chk #(.WBITS(WBITS), .NSEG(NSEG)) u_chk (.*);

// File: tb/pcm_weight_prog_tb.sv
`timescale 1ns/1ps
module pcm_weight_prog_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [3:0]  req_code = '0;
  logic        cfg_serial = 1'b0;
  logic [7:0]  cfg_anneal_cnt = 8'd2, cfg_melt_cnt = 8'd3;
  logic [15:0] cfg_anneal_on = 16'd3, cfg_anneal_per = 16'd5;
  logic [15:0] cfg_melt_on = 16'd1, cfg_melt_per = 16'd2;
  logic [15:0] cfg_settle = 16'd2;
  logic [14:0] heat_en;
  logic        pulse_melt, done, stored_valid;
  logic [3:0]  stored_code;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pcm_weight_prog u_dut (.*);

  // model state and expected stream
  int m_val = 0;
  bit m_known = 0;
  int q_heat[$];
  bit q_melt[$];
  bit q_done[$];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int one_min(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic void push_train(input int mask, input bit melt);
    int cnt = melt ? one_min(cfg_melt_cnt) : one_min(cfg_anneal_cnt);
    int on  = melt ? one_min(cfg_melt_on)  : one_min(cfg_anneal_on);
    int per = melt ? one_min(cfg_melt_per) : one_min(cfg_anneal_per);
    for (int p = 0; p < cnt; p++)
      for (int s = 0; s < per; s++) begin
        q_heat.push_back(s < on ? mask : 0);
        q_melt.push_back(melt);
        q_done.push_back(1'b0);
      end
  endfunction

  // expand one command into its expected per-cycle outputs
  function automatic void build(input int code);
    int tr_mask[$];
    bit tr_melt[$];
    int from_lvl, to_lvl, win;
    q_heat.delete(); q_melt.delete(); q_done.delete();
    if (!m_known) begin
      from_lvl = 15;  // all melted first (R9)
      to_lvl = 0;
    end else begin
      from_lvl = m_val;
      to_lvl = code;
    end
    // melt part: segments to_lvl..from_lvl-1, highest first
    if (from_lvl > to_lvl) begin
      if (cfg_serial) begin
        for (int k = from_lvl - 1; k >= to_lvl; k--) begin
          tr_mask.push_back(1 << k); tr_melt.push_back(1'b1);
        end
      end else begin
        win = 0;
        for (int k = to_lvl; k < from_lvl; k++) win |= (1 << k);
        tr_mask.push_back(win); tr_melt.push_back(1'b1);
      end
    end
    // anneal part
    begin
      int a_lo = m_known ? m_val : 0;
      if (code > a_lo) begin
        if (cfg_serial) begin
          for (int k = a_lo; k < code; k++) begin
            tr_mask.push_back(1 << k); tr_melt.push_back(1'b0);
          end
        end else begin
          win = 0;
          for (int k = a_lo; k < code; k++) win |= (1 << k);
          tr_mask.push_back(win); tr_melt.push_back(1'b0);
        end
      end
    end
    for (int t = 0; t < tr_mask.size(); t++) begin
      if (t > 0 && cfg_serial)
        for (int g = 0; g < cfg_settle; g++) begin
          q_heat.push_back(0); q_melt.push_back(1'b0); q_done.push_back(1'b0);
        end
      push_train(tr_mask[t], tr_melt[t]);
    end
    q_heat.push_back(0); q_melt.push_back(1'b0); q_done.push_back(1'b1);
  endfunction

  task automatic check_idle(input string tag);
    chk({tag, " R1 ready idle"}, req_ready, 1);
    chk({tag, " R10 heaters idle"}, heat_en, 0);
    chk({tag, " R2 done idle"}, done, 0);
    chk({tag, " R10 stored idle"}, stored_code, m_val);
    chk({tag, " R9 valid idle"}, stored_valid, m_known);
  endtask

  // starts and ends at a falling edge of an idle cycle
  task automatic run_cmd(input string tag, input int code, input bit hold, input int hold_code);
    int n;
    check_idle(tag);
    req_valid = 1'b1;
    req_code  = 4'(code);
    build(code);
    n = q_heat.size();
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk({tag, " heaters"}, heat_en, q_heat[i]);
      chk({tag, " R6 pulse type"}, pulse_melt, q_melt[i]);
      chk({tag, " R2 done"}, done, q_done[i]);
      chk({tag, " R1 ready busy"}, req_ready, 0);
      if (q_done[i]) begin
        chk({tag, " R2 stored"}, stored_code, code);
        chk({tag, " R2 valid"}, stored_valid, 1);
      end else begin
        chk({tag, " R10 stored held"}, stored_code, m_val);
      end
      if (hold && n > 2 && i == n / 2) begin
        req_valid = 1'b1;       // R1: arrives while busy
        req_code  = 4'(hold_code);
      end
      @(negedge clk);
    end
    m_val = code;
    m_known = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset valid", stored_valid, 0);
    chk("R1 reset ready", req_ready, 1);
    chk("R10 reset heaters", heat_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 R7 first command: melt all, then anneal to 5
    run_cmd("R9 R7 init5", 5, 0, 0);
    run_cmd("R3 R7 up9", 9, 0, 0);
    run_cmd("R5 equal9", 9, 0, 0);
    cfg_serial = 1'b1;
    // R4 R8 serial lower with a request held across done (R1)
    run_cmd("R4 R8 down6", 6, 1, 10);
    chk("R1 held request pending", req_valid, 1);
    run_cmd("R3 R8 up10 held", 10, 0, 0);
    cfg_settle = 16'd0;
    run_cmd("R4 R8 down0 nogap", 0, 0, 0);
    cfg_serial = 1'b0;
    run_cmd("R3 R7 up15", 15, 0, 0);
    // R6 zero fields count as one; on-time past period keeps heater on
    cfg_melt_cnt = 8'd0; cfg_melt_on = 16'd0; cfg_melt_per = 16'd0;
    run_cmd("R4 R6 down14 zeros", 14, 0, 0);
    cfg_anneal_cnt = 8'd2; cfg_anneal_on = 16'd6; cfg_anneal_per = 16'd3;
    run_cmd("R3 R6 up15 longon", 15, 0, 0);
    // R9 reset loses the state; serial init to level 0
    rst_n = 1'b0;
    m_known = 1'b0;
    m_val = 0;
    @(negedge clk);
    chk("R9 valid after reset", stored_valid, 0);
    rst_n = 1'b1;
    cfg_serial = 1'b1; cfg_settle = 16'd1;
    cfg_melt_cnt = 8'd2; cfg_melt_on = 16'd1; cfg_melt_per = 16'd2;
    @(negedge clk);
    run_cmd("R9 R8 init0", 0, 0, 0);
    run_cmd("R3 R8 up3", 3, 0, 0);
    check_idle("final");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule